// File: doc/BRIEF.md
# Single-Channel Block Transfer Controller

This block moves a block of words between one peripheral and memory without the processor touching each word. Software loads a start address and a word count through a small register port, then writes a control word that picks the direction and the bus-sharing mode and carries a start bit. From then on the block paces itself on the peripheral's request line. It asks the processor for the system bus and waits for the grant. For each word it drives the memory address and a read or write strobe, and answers the peripheral with a one-cycle acknowledge.

Two bus-sharing modes exist. In burst mode the bus is kept from the first grant until the last word. In cycle-stealing mode the bus is handed back after every word and requested again only when the peripheral asks for the next one. When the count runs out, an interrupt line rises and stays high until software reads the status register or writes the control register.

Top module: `dmac_top`

## Requirements
- R1: After reset, bus_req, dev_ack, mem_rd, mem_wr and irq are low, and the address, count and status registers read zero.
- R2: With cs and wr_en high, reg_sel 0 loads the address, 1 loads the word count and 2 loads the control word. Control bit 0 is the direction (1 = peripheral to memory using mem_wr, 0 = memory to peripheral using mem_rd), bit 1 selects cycle stealing (0 = burst) and bit 2 starts a transfer. reg_sel 0..2 read back the address, the count and the mode bits, with the start bit reading 0. reg_sel 3 reads status: bit 0 busy, bit 1 done.
- R3: After a start with a nonzero count, bus_req stays low until dev_req is seen. No memory strobe occurs until bus_grant has been seen high while bus_req is high.
- R4: Each word produces exactly one cycle with dev_ack high together with one strobe (mem_wr if the direction is 1, mem_rd if it is 0), while mem_addr holds the current address. After that cycle the address has gone up by one and the count down by one.
- R5: In burst mode, bus_req stays high between words of a block and falls in the cycle after the last word's strobe.
- R6: In cycle-stealing mode, bus_req falls in the cycle after every word's strobe. In either mode, bus_req rises only in the cycle after dev_req was high.
- R7: When the count reaches zero, the transfer ends: busy clears, done is set and irq goes high.
- R8: irq stays high until a status read (reg_sel 3 with rd_en) or a control write. Reads of other registers leave it high.
- R9: While busy, writes to the address, count and control registers have no effect.
- R10: A start with a count of zero makes no bus request and sets done and irq at the next clock edge.
- R11: The address wraps from its all-ones value to zero during a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port select |
| reg_sel | input | 2 | Register index |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears done) |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data |
| bus_req | output | 1 | System bus request to the processor |
| bus_grant | input | 1 | System bus grant from the processor |
| dev_req | input | 1 | Peripheral word request |
| dev_ack | output | 1 | Peripheral word acknowledge |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Random blocks of one to six words are run in both directions and both modes, with random start addresses. The peripheral request and the bus grant are driven with random delays. Burst and stolen-cycle runs differ only in when bus_req must fall, so each word's release is checked against the mode, and a request that rises without a preceding dev_req is caught in both modes. Directed cases cover a start address next to the top of the address space (wrap), a zero count (immediate completion, no bus request), writes issued while busy (must read back unchanged), and a grant withheld for several cycles (no strobe may appear).

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DEV,
    ST_ARB,
    ST_XFER,
    ST_HOLD
  } seq_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_DIR_BIT   = 0;
  localparam int CTRL_STEAL_BIT = 1;
  localparam int CTRL_GO_BIT    = 2;

  typedef struct packed {
    logic steal;
    logic dir;
  } xfer_cfg_t;
endpackage

// File: rtl/dmac_cfg.sv
module dmac_cfg
  import dmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic [1:0]      reg_sel,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  input  logic            busy,
  input  logic            done_set,
  input  logic [AW-1:0]   addr_q,
  input  logic [CW-1:0]   cnt_q,
  output logic            load_addr,
  output logic            load_cnt,
  output logic            go,
  output xfer_cfg_t       cfg,
  output logic            done,
  output logic [DW-1:0]   rdata
);
  logic      wr_ok;
  logic      ctrl_wr;
  logic      stat_rd;
  xfer_cfg_t cfg_q, cfg_d;
  logic      done_q, done_d;

  assign wr_ok     = cs && wr_en && !busy;
  assign load_addr = wr_ok && (reg_sel == SEL_ADDR);
  assign load_cnt  = wr_ok && (reg_sel == SEL_CNT);
  assign ctrl_wr   = wr_ok && (reg_sel == SEL_CTRL);
  assign go        = ctrl_wr && wdata[CTRL_GO_BIT];
  assign stat_rd   = cs && rd_en && (reg_sel == SEL_STAT);

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_wr) begin
      cfg_d.dir   = wdata[CTRL_DIR_BIT];
      cfg_d.steal = wdata[CTRL_STEAL_BIT];
    end
  end

  always_comb begin
    done_d = done_q;
    if (stat_rd || ctrl_wr) done_d = 1'b0;
    if (done_set)           done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR: rdata = DW'(addr_q);
      SEL_CNT:  rdata = DW'(cnt_q);
      SEL_CTRL: rdata = DW'({cfg_q.steal, cfg_q.dir});
      default:  rdata = DW'({done_q, busy});
    endcase
  end

  assign cfg  = cfg_q;
  assign done = done_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !stat_rd && !ctrl_wr) |=> done_q); // R8
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/dmac_counters.sv
module dmac_counters #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          load_addr,
  input  logic          load_cnt,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          cnt_zero,
  output logic          cnt_last
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          addr_en, cnt_en;

  assign addr_en = load_addr || step;
  assign cnt_en  = load_cnt || step;

  always_comb begin
    if (load_addr) addr_d = wdata[AW-1:0];
    else           addr_d = addr_q + ADDR_ONE;
    if (load_cnt)  cnt_d  = wdata[CW-1:0];
    else           cnt_d  = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_addr) |=> (addr_q == $past(addr_q) + ADDR_ONE)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_cnt) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R4
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  xfer_cfg_t cfg,
  input  logic      cnt_zero,
  input  logic      cnt_last,
  input  logic      dev_req,
  input  logic      bus_grant,
  output logic      busy,
  output logic      bus_req,
  output logic      dev_ack,
  output logic      mem_rd,
  output logic      mem_wr,
  output logic      step,
  output logic      done_set
);
  seq_state_t state_q, state_d;
  logic       xfer;

  always_comb begin
    state_d  = state_q;
    done_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) done_set = 1'b1;
          else          state_d  = ST_WAIT_DEV;
        end
      end
      ST_WAIT_DEV: if (dev_req) state_d = ST_ARB;
      ST_ARB:      if (bus_grant) state_d = ST_XFER;
      ST_XFER: begin
        if (cnt_last) begin
          state_d  = ST_IDLE;
          done_set = 1'b1;
        end else if (cfg.steal) begin
          state_d = ST_WAIT_DEV;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD:     if (dev_req && bus_grant) state_d = ST_XFER;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign xfer    = (state_q == ST_XFER);
  assign busy    = (state_q != ST_IDLE);
  assign bus_req = (state_q == ST_ARB) || xfer || (state_q == ST_HOLD);
  assign dev_ack = xfer;
  assign mem_rd  = xfer && !cfg.dir;
  assign mem_wr  = xfer && cfg.dir;
  assign step    = xfer;

  AST_STROBE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> $past(bus_grant)); // R3
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cnt_last) |=> !bus_req); // R5
  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cnt_last && !cfg.steal) |=> bus_req); // R5
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cfg.steal) |=> !bus_req); // R6
  AST_REQ_AFTER_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dev_req)); // R6
  AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && cnt_zero) |=> !busy); // R10
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          dev_req,
  output logic          dev_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          irq
);
  logic          load_addr, load_cnt, go, step, done_set, busy;
  logic          cnt_zero, cnt_last, done;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  xfer_cfg_t     cfg;

  dmac_cfg #(.DW(DW), .AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cs(cs), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .busy(busy), .done_set(done_set),
    .addr_q(addr_q), .cnt_q(cnt_q), .load_addr(load_addr),
    .load_cnt(load_cnt), .go(go), .cfg(cfg), .done(done), .rdata(rdata)
  );

  dmac_counters #(.DW(DW), .AW(AW), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .load_addr(load_addr),
    .load_cnt(load_cnt), .step(step), .addr_q(addr_q), .cnt_q(cnt_q),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  dmac_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg(cfg), .cnt_zero(cnt_zero),
    .cnt_last(cnt_last), .dev_req(dev_req), .bus_grant(bus_grant),
    .busy(busy), .bus_req(bus_req), .dev_ack(dev_ack), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .step(step), .done_set(done_set)
  );

  assign mem_addr = addr_q;
  assign irq      = done;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R4
  AST_ACK_WITH_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (bus_req && (mem_rd || mem_wr))); // R4
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req); // R7
endmodule

// File: tb/dmac_top_test.sv
`timescale 1ns/1ps
module dmac_top_test;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          bus_req, dev_ack, mem_rd, mem_wr, irq;
  logic          bus_grant = 1'b0, dev_req = 1'b0;
  logic [AW-1:0] mem_addr;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  dmac_top #(.DW(DW), .AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .dev_req(dev_req), .dev_ack(dev_ack),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k);
    return a + AW'(k);
  endfunction

  function automatic logic [DW-1:0] ctrl_word(input bit dir, input bit steal, input bit go);
    return DW'({go, steal, dir});
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; reg_sel = sel; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; rd_en = 1'b1; reg_sel = sel;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd_en = 1'b0;
  endtask

  // Drive peripheral and grant for a started block and check every word.
  task automatic drive_block(input logic [AW-1:0] a, input int n, input bit dir, input bit steal);
    int  k = 0;
    bit  prev_strobe = 1'b0;
    bit  prev_bus = bus_req;
    bit  last_dev = dev_req;
    bit  s;
    bit  finished = 1'b0;
    logic [DW-1:0] d;
    for (int cyc = 0; cyc < 5000 && !finished; cyc++) begin
      @(negedge clk);
      s = mem_rd | mem_wr;
      if (prev_strobe && (steal || k == n))
        check(!bus_req, steal ? "R6 release per word" : "R5 release after last", bus_req, 0);
      if (prev_strobe && !steal && k != n)
        check(bus_req, "R5 bus held in burst", bus_req, 1);
      if (bus_req && !prev_bus)
        check(last_dev, "R6 request follows dev_req", last_dev, 1);
      if (s) begin
        check(bus_grant, "R3 strobe only after grant", bus_grant, 1);
        check(mem_addr == exp_addr(a, k), "R4 R11 word address", mem_addr, exp_addr(a, k));
        check(mem_wr == dir && mem_rd == !dir, "R4 strobe direction", {mem_wr, mem_rd}, {dir, !dir});
        check(dev_ack, "R4 acknowledge with strobe", dev_ack, 1);
        k++;
      end else if (dev_ack) begin
        check(1'b0, "R4 acknowledge without strobe", dev_ack, 0);
      end
      if (irq) finished = 1'b1;
      prev_strobe = s;
      prev_bus = bus_req;
      if (s)            dev_req = ($urandom % 2) == 1;
      else if (!dev_req) dev_req = ($urandom % 3) != 0;
      bus_grant = bus_req && (bus_grant || (($urandom % 2) == 1));
      last_dev = dev_req;
    end
    dev_req = 1'b0;
    bus_grant = 1'b0;
    check(finished, "R7 block completes", finished, 1);
    check(k == n, "R7 word count", k, n);
    for (int w = 0; w < int'($urandom % 4); w++) @(negedge clk);
    check(irq, "R8 irq held", irq, 1);
    cpu_read(2'd0, d);
    check(d == DW'(exp_addr(a, n)), "R4 final address", d, exp_addr(a, n));
    check(irq, "R8 irq kept after non-status read", irq, 1);
    cpu_read(2'd1, d);
    check(d == '0, "R4 final count", d, 0);
    cpu_read(2'd3, d);
    check(d == DW'(2'b10), "R7 status done not busy", d, 2'b10);
    cpu_read(2'd3, d);
    check(d == '0, "R8 status read clears done", d, 0);
    check(!irq, "R8 irq cleared", irq, 0);
  endtask

  task automatic run_block(input logic [AW-1:0] a, input int n, input bit dir, input bit steal);
    cpu_write(2'd0, DW'(a));
    cpu_write(2'd1, DW'(n));
    cpu_write(2'd2, ctrl_word(dir, steal, 1'b1));
    drive_block(a, n, dir, steal);
  endtask

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(!bus_req && !dev_ack && !mem_rd && !mem_wr && !irq, "R1 outputs idle",
          {bus_req, dev_ack, mem_rd, mem_wr, irq}, 0);
    cpu_read(2'd0, d); check(d == '0, "R1 address reset", d, 0);
    cpu_read(2'd1, d); check(d == '0, "R1 count reset", d, 0);
    cpu_read(2'd3, d); check(d == '0, "R1 status reset", d, 0);

    // R2 register write and read back
    cpu_write(2'd0, 16'h1234);
    cpu_write(2'd1, 16'h0005);
    cpu_write(2'd2, ctrl_word(1'b1, 1'b1, 1'b0));
    cpu_read(2'd0, d); check(d == 16'h1234, "R2 address readback", d, 16'h1234);
    cpu_read(2'd1, d); check(d == 16'h0005, "R2 count readback", d, 5);
    cpu_read(2'd2, d); check(d == 16'h0003, "R2 control readback", d, 3);
    cpu_read(2'd3, d); check(d == '0, "R2 status idle", d, 0);

    // R3 and R9: wait for peripheral, writes ignored while busy, grant withheld
    cpu_write(2'd0, 16'h0040);
    cpu_write(2'd1, 16'h0002);
    cpu_write(2'd2, ctrl_word(1'b0, 1'b0, 1'b1));
    repeat (4) @(negedge clk);
    check(!bus_req, "R3 no request before dev_req", bus_req, 0);
    cpu_read(2'd3, d); check(d == 16'h0001, "R2 status busy", d, 1);
    cpu_write(2'd0, 16'h9999);
    cpu_write(2'd1, 16'h0007);
    cpu_write(2'd2, ctrl_word(1'b1, 1'b1, 1'b1));
    cpu_read(2'd0, d); check(d == 16'h0040, "R9 address write ignored", d, 16'h0040);
    cpu_read(2'd1, d); check(d == 16'h0002, "R9 count write ignored", d, 2);
    cpu_read(2'd2, d); check(d == 16'h0000, "R9 control write ignored", d, 0);
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(bus_req && !mem_rd && !mem_wr, "R3 no strobe without grant",
            {bus_req, mem_rd, mem_wr}, 3'b100);
    end
    drive_block(16'h0040, 2, 1'b0, 1'b0);

    // R11 address wrap, burst and stealing
    run_block(16'hFFFE, 3, 1'b1, 1'b0);
    run_block(16'hFFFF, 2, 1'b0, 1'b1);

    // R10 zero count start; control write clears irq (R8)
    cpu_write(2'd1, 16'h0000);
    cpu_write(2'd2, ctrl_word(1'b0, 1'b0, 1'b1));
    check(irq, "R10 immediate done", irq, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!bus_req, "R10 no bus request", bus_req, 0);
    end
    cpu_read(2'd2, d);
    check(irq, "R8 irq kept after control read", irq, 1);
    cpu_write(2'd2, ctrl_word(1'b0, 1'b0, 1'b0));
    check(!irq, "R8 control write clears irq", irq, 0);

    // Random blocks across modes and directions
    for (int t = 0; t < 16; t++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      run_block(a, 1 + int'($urandom % 6), ($urandom % 2) == 1, ($urandom % 2) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule